// File: doc/BRIEF.md
# Prioritized Interrupt Group with Vector Register

This block gathers up to sixteen single-cycle peripheral event requests into one interrupt group and raises a single request line toward the CPU. Each event source owns one bit in a pending register and one bit in an enable register. While any pending bit is also enabled, the request line stays high.

Software services the group by reading a vector location. The value returned names the most urgent pending, enabled source, and the act of reading removes exactly that pending bit. The code is produced combinationally from the current pending and enable state. A source that fires in the very cycle of a vector read is therefore never cleared by that read, and the next read reports it. A separate inspection input lets a debugger look at the vector without disturbing any pending bit. Bus accesses complete in one cycle, and the ready line never drops.

Top module: `irq_vec_group`

## Requirements
- R1: After synchronous reset, the pending register, the enable register, the vector read value and `cpu_irq` are all zero.
- R2: An `evt_in` bit high in a cycle sets the matching pending bit at that clock edge, whether or not the bit is enabled. The pending register (address 0) reads back every pending bit.
- R3: A write to address 0 clears each pending bit whose `bus_wdata` bit is one and leaves the bits written with zero unchanged.
- R4: When a clearing write and a new event hit the same pending bit in the same cycle, the bit ends up set.
- R5: The enable register (address 1) is read/write. `cpu_irq` is high in exactly the cycles in which some pending bit is also enabled.
- R6: A read of address 2 returns, in the same cycle, index+1 of the lowest-numbered bit that is both pending and enabled. Bit 0 has the highest priority. The value is 0 when no such bit exists, and it is zero-extended to the data width.
- R7: A read of address 2 with `dbg_peek` low clears, at that clock edge, exactly the pending bit it reported. All other pending bits are unchanged.
- R8: An event on a higher-priority bit arriving in the same cycle as a clearing vector read stays pending, and the next vector read reports it.
- R9: A clearing vector read that returns 0 changes no pending bit.
- R10: A vector read with `dbg_peek` high returns the same value as R6 and clears no pending bit.
- R11: Writes to address 2 change neither the pending register, the enable register nor the vector.
- R12: `bus_ready` is high in every cycle, including during every access.
- R13: Address 3 reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | 16 | One event request per source; high means the event fires in this cycle |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 2 | 0 pending, 1 enable, 2 vector, 3 unused |
| bus_wdata | input | 16 | Write data |
| dbg_peek | input | 1 | Turns a vector read into a non-clearing inspection |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| bus_ready | output | 1 | Access completion, always high |
| cpu_irq | output | 1 | Group request toward the CPU |

## Verification
Read data is combinational, so the bench samples `bus_rdata` one time step after it drives an access, before the clock edge that completes the access. Pending, enable and clearing effects take place at that edge. They become visible on `cpu_irq` and through a readback access in the following cycle, and the bench checks them there with a separate read of address 0, 1 or 2. The same-cycle race of R8 is checked across every pair of a lower- and a higher-priority source. Mask, pending and clear patterns come from a bench-side shift-register sequence, and the expected values are computed arithmetically from the requirements.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;

    typedef enum logic [1:0] {
        LOC_PEND = 2'd0,
        LOC_ENAB = 2'd1,
        LOC_VECT = 2'd2,
        LOC_NONE = 2'd3
    } loc_e;

    typedef struct packed {
        logic pend_w1c;
        logic enab_wr;
        logic vec_take;
    } acc_dec_t;

    function automatic int vec_bits(input int n_src);
        return $clog2(n_src + 1);
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_SRC = 16,
    parameter int VW      = 5
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [VW-1:0]      code,
    output logic [NUM_SRC-1:0] winner
);
    always_comb begin
        code   = '0;
        winner = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                code   = VW'(i + 1);
                winner = NUM_SRC'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               w1c_en,
    input  logic [NUM_SRC-1:0] w1c_bits,
    input  logic               take_en,
    input  logic [NUM_SRC-1:0] take_bit,
    output logic [NUM_SRC-1:0] pend
);
    logic [NUM_SRC-1:0] clr;

    always_comb begin
        clr = '0;
        if (w1c_en)  clr = clr | w1c_bits;
        if (take_en) clr = clr | take_bit;
    end

    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend[b] <= 1'b0;
            else if (evt[b])
                pend[b] <= 1'b1;
            else if (clr[b])
                pend[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port
    import irq_grp_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int VW      = 5
) (
    input  logic               sel,
    input  logic               wr,
    input  logic [1:0]         addr,
    input  logic               peek,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] enab,
    input  logic [VW-1:0]      code,
    output acc_dec_t           dec,
    output logic [NUM_SRC-1:0] rdata
);
    loc_e loc;

    always_comb begin
        loc = loc_e'(addr);
        dec = '0;
        rdata = '0;
        if (sel) begin
            if (wr) begin
                dec.pend_w1c = (loc == LOC_PEND);
                dec.enab_wr  = (loc == LOC_ENAB);
            end else begin
                unique case (loc)
                    LOC_PEND: rdata = pend;
                    LOC_ENAB: rdata = enab;
                    LOC_VECT: begin
                        rdata        = NUM_SRC'(code);
                        dec.vec_take = !peek;
                    end
                    default:  rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_vec_group.sv
module irq_vec_group
    import irq_grp_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    input  logic               dbg_peek,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               bus_ready,
    output logic               cpu_irq
);
    localparam int VW = vec_bits(NUM_SRC);

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] win;
    logic [VW-1:0]      code;
    acc_dec_t           dec;

    assign live = flag_q & mask_q;

    irq_prio_enc #(.NUM_SRC(NUM_SRC), .VW(VW)) u_enc (
        .req(live), .code(code), .winner(win)
    );

    irq_bus_port #(.NUM_SRC(NUM_SRC), .VW(VW)) u_port (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .peek(dbg_peek),
        .pend(flag_q), .enab(mask_q), .code(code),
        .dec(dec), .rdata(bus_rdata)
    );

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst(rst), .evt(evt_in),
        .w1c_en(dec.pend_w1c), .w1c_bits(bus_wdata),
        .take_en(dec.vec_take), .take_bit(win),
        .pend(flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (dec.enab_wr)
            mask_q <= bus_wdata;
    end

    assign cpu_irq   = |live;
    assign bus_ready = 1'b1;
endmodule

// File: rtl/irq_vec_group_chk.sv
module irq_vec_group_chk #(
    parameter int NUM_SRC = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_in,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [1:0]         bus_addr,
    input logic               dbg_peek,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               cpu_irq,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] mask
);
    logic vrd, take, vwr, quiet;
    assign vrd   = bus_sel && !bus_wr && bus_addr == 2'd2;
    assign take  = vrd && !dbg_peek;
    assign vwr   = bus_sel && bus_wr && bus_addr == 2'd2;
    assign quiet = (evt_in == '0);

    AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((flags & $past(evt_in)) == $past(evt_in))); // R2

    AST_IRQ_VS_VEC: assert property (@(posedge clk) disable iff (rst)
        vrd |-> (cpu_irq == (bus_rdata != '0))); // R5

    AST_TAKE_ONE: assert property (@(posedge clk) disable iff (rst)
        (take && quiet && bus_rdata != '0) |=>
        ($countones(flags) + 1 == $countones($past(flags)))); // R7

    AST_NO_LOSS_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> ($countones($past(flags) & ~flags) <= 1)); // R8

    AST_EMPTY_TAKE: assert property (@(posedge clk) disable iff (rst)
        (take && bus_rdata == '0) |=> ((flags & $past(flags)) == $past(flags))); // R9

    AST_PEEK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (vrd && dbg_peek) |=> ((flags & $past(flags)) == $past(flags))); // R10

    AST_VEC_WR_IGN: assert property (@(posedge clk) disable iff (rst)
        (vwr && quiet) |=> ($stable(flags) && $stable(mask))); // R11
endmodule

bind irq_vec_group irq_vec_group_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .dbg_peek(dbg_peek),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq),
    .flags(flag_q), .mask(mask_q)
);

// File: tb/irq_vec_group_test.sv
module irq_vec_group_test;
    localparam int N = 16;
    localparam time CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_in = '0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0, dbg_peek = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         bus_ready, cpu_irq;

    int n_chk = 0, n_fail = 0;

    irq_vec_group #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .dbg_peek(dbg_peek), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .cpu_irq(cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Access: drive after a falling edge, sample read data before the rising edge.
    task automatic op(input logic s, input logic w, input logic [1:0] a,
                      input logic [N-1:0] wd, input logic pk,
                      input logic [N-1:0] ev, output logic [N-1:0] rd);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
        dbg_peek = pk; evt_in = ev;
        #1;
        rd = bus_rdata;
        check(bus_ready === 1'b1, "R12", int'(bus_ready), 1);
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; dbg_peek = 0; evt_in = 0;
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] exp_vec(input logic [N-1:0] f, input logic [N-1:0] m);
        logic [N-1:0] l;
        l = f & m;
        for (int i = 0; i < N; i++)
            if (l[i]) return N'(i + 1);
        return '0;
    endfunction

    task automatic rd_reg(input logic [1:0] a, output logic [N-1:0] v);
        op(1, 0, a, '0, 0, '0, v);
    endtask

    initial begin
        #(CLK_PERIOD * 30000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] r, lfsr, m, p, c;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);

        // R1 reset state
        check(cpu_irq === 1'b0, "R1 irq", int'(cpu_irq), 0);
        rd_reg(0, r); check(r === '0, "R1 pend", int'(r), 0);
        rd_reg(1, r); check(r === '0, "R1 enab", int'(r), 0);
        rd_reg(2, r); check(r === '0, "R1 vec", int'(r), 0);

        // R5 enable register read/write
        op(1, 1, 1, '1, 0, '0, r);
        rd_reg(1, r); check(r === '1, "R5 enab rw", int'(r), 16'hffff);

        // Single-source sweep: R2, R5, R6, R7
        for (int i = 0; i < N; i++) begin
            op(0, 0, 0, '0, 0, N'(1) << i, r);
            check(cpu_irq === 1'b1, "R5 irq up", int'(cpu_irq), 1);
            rd_reg(0, r); check(r === (N'(1) << i), "R2 set", int'(r), 1 << i);
            rd_reg(2, r); check(r === N'(i + 1), "R6 code", int'(r), i + 1);
            rd_reg(0, r); check(r === '0, "R7 cleared", int'(r), 0);
            check(cpu_irq === 1'b0, "R5 irq down", int'(cpu_irq), 0);
        end

        // Same-cycle race across all priority pairs: R8
        for (int j = 1; j < N; j++) begin
            for (int i = 0; i < j; i++) begin
                op(0, 0, 0, '0, 0, N'(1) << j, r);
                op(1, 0, 2, '0, 0, N'(1) << i, r);
                check(r === N'(j + 1), "R8 first code", int'(r), j + 1);
                rd_reg(0, r); check(r === (N'(1) << i), "R8 kept", int'(r), 1 << i);
                rd_reg(2, r); check(r === N'(i + 1), "R8 next code", int'(r), i + 1);
            end
        end

        // Pattern sweep: R2 masked visibility, R3, R5, R6, R10, R11, R13
        lfsr = 16'hace1;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; m = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; p = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; c = lfsr;
            op(1, 1, 1, m, 0, p, r);
            rd_reg(0, r); check(r === p, "R2 masked visible", int'(r), int'(p));
            check(cpu_irq === (|(p & m)), "R5 irq", int'(cpu_irq), int'(|(p & m)));
            op(1, 0, 2, '0, 1, '0, r);
            check(r === exp_vec(p, m), "R10 peek code", int'(r), int'(exp_vec(p, m)));
            rd_reg(0, r); check(r === p, "R10 no clear", int'(r), int'(p));
            op(1, 1, 2, '1, 0, '0, r);
            op(1, 1, 3, '1, 0, '0, r);
            rd_reg(0, r); check(r === p, "R11 pend kept", int'(r), int'(p));
            rd_reg(1, r); check(r === m, "R11 enab kept", int'(r), int'(m));
            rd_reg(3, r); check(r === '0, "R13 zero", int'(r), 0);
            rd_reg(2, r); check(r === exp_vec(p, m), "R6 code", int'(r), int'(exp_vec(p, m)));
            p = p & ~(r == '0 ? '0 : (N'(1) << (r - 1)));
            op(1, 1, 0, c, 0, '0, r);
            rd_reg(0, r); check(r === (p & ~c), "R3 w1c", int'(r), int'(p & ~c));
            op(1, 1, 0, '1, 0, '0, r);
        end

        // R4 clear and event on the same bit
        op(1, 1, 1, '1, 0, '0, r);
        for (int k = 0; k < N; k++) begin
            op(0, 0, 0, '0, 0, N'(1) << k, r);
            op(1, 1, 0, '1, 0, N'(1) << k, r);
            rd_reg(0, r); check(r === (N'(1) << k), "R4 race set", int'(r), 1 << k);
            op(1, 1, 0, '1, 0, '0, r);
        end

        // R9 empty clearing read; masked pending bit survives
        op(1, 1, 1, 16'h00ff, 0, 16'h0100, r);
        op(1, 0, 2, '0, 0, '0, r);
        check(r === '0, "R9 empty code", int'(r), 0);
        rd_reg(0, r); check(r === 16'h0100, "R9 nothing cleared", int'(r), 16'h0100);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule